// File: doc/BRIEF.md
# Dynamic range gain controller

This block decides, sample by sample, how much boost a front-end amplifier should apply. It takes a stream of signed signal-level estimates in dB relative to full scale (Q8, 256 counts per dB). Each level is compared against a programmable threshold. The comparison uses separate hysteresis margins for going louder and for going quieter. A crossing has to persist for a programmed number of consecutive samples before the block changes mode.

In the boost mode the target gain is the programmed maximum. In the unity mode the target is 0 dB. The applied gain approaches its target through a one-pole Q31 filter, and attack and release each have their own coefficient pair. Each accepted level produces one gain result in dB, Q8.

Both streams use valid/ready handshakes. A level is accepted on a clock edge where `lvl_valid` and `lvl_ready` are both high. `lvl_ready` is high whenever the result register is empty, or is being drained in the same cycle. A result stays presented, unchanged, until the consumer takes it with `gain_ready`. While the consumer stalls, no new level is accepted. Configuration pins are plain levels that are sampled on each accepted level.

Top module: `dyn_gain_ctrl`

## Requirements
- R1: The threshold code n (0..9) selects -(12+6n) dB, i.e. -(12+6n)*256 in Q8. Codes 10..15 behave as code 9 (-66 dB).
- R2: The maximum-gain code n (0..14) selects 2(n+1) dB. Code 15 behaves as code 14 (30 dB).
- R3: With `ovr_en`=0 the block ignores the programmed parameter pins and uses fixed values:
  - attack hysteresis 0x100
  - release hysteresis 0x300
  - attack debounce 0x200
  - release debounce 0x4B000
  - attack alpha/beta 0x50FC645C/0x2F039BA4
  - release alpha/beta 0x7FB51650/0x004AE9B0

  With `ovr_en`=1 it uses the pins.
- R4: In unity mode, each accepted level strictly below threshold minus release hysteresis increments a release count. Any other level clears that count. When the count reaches the release debounce shifted right by 8, the block enters boost mode and both counts clear. A debounce of 0 acts as 1.
- R5: In boost mode, each accepted level strictly above threshold plus attack hysteresis increments an attack count. Any other level clears that count. When the count reaches the attack debounce shifted right by 8, the block enters unity mode and both counts clear.
- R6: On each accepted level the internal gain g (Q8 with 16 extra fraction bits) becomes (alpha*g + beta*target) >>> 31. The computation uses 64-bit signed products. The target and the coefficient pair are chosen by the mode after this sample's decision: unity mode uses the attack pair and a target of 0; boost mode uses the release pair and the maximum gain. `gain_db` equals g >>> 16.
- R7: Every update saturates g to the range from 0 to the current maximum gain, so a lowered maximum clamps the gain on the next accepted level.
- R8: After a synchronous active-high reset the block is in unity mode with both counts cleared and g = 0. `gain_valid` is 0 and `lvl_ready` is 1.
- R9: A result appears with `gain_valid`=1 on the edge after its level is accepted. While `gain_valid`=1 and `gain_ready`=0, `gain_db` holds and `lvl_ready`=0.
- R10: A level presented while `lvl_ready`=0 is not consumed, and it leaves mode, counts and gain untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_valid | input | 1 | Level sample valid |
| lvl_ready | output | 1 | Level sample can be accepted |
| lvl_db | input | LVL_W | Signed level estimate, dBFS Q8 |
| gain_valid | output | 1 | Gain result valid |
| gain_ready | input | 1 | Consumer takes the gain result |
| gain_db | output | GAIN_W | Applied gain, dB Q8 |
| thr_code | input | 4 | Threshold code |
| max_code | input | 4 | Maximum-gain code |
| ovr_en | input | 1 | Use programmed parameters instead of fixed values |
| att_hyst | input | 32 | Attack hysteresis, dB Q8 |
| rel_hyst | input | 32 | Release hysteresis, dB Q8 |
| att_deb | input | 32 | Attack debounce, samples Q8 |
| rel_deb | input | 32 | Release debounce, samples Q8 |
| att_alpha | input | 32 | Attack alpha, Q31 |
| att_beta | input | 32 | Attack beta, Q31 |
| rel_alpha | input | 32 | Release alpha, Q31 |
| rel_beta | input | 32 | Release beta, Q31 |

## Verification
Every threshold code is crossed with every maximum-gain code. Each combination is driven with the same short level script placed relative to its own threshold. The script contains broken runs of quiet samples, a level sitting exactly at the hysteresis bound, and sustained loud and quiet runs. This separates a correct strict comparison and count clearing from off-by-one debounce, and it exposes a wrong decode of either code table.

A long run with the fixed parameters, while the parameter pins hold decoy values, shows the release fires on exactly the 1200th quiet sample. Coefficient pairs summing above one and below zero drive the gain into both saturation limits. A stalled consumer with a conflicting level waiting at the input shows that the held result does not move and that the stalled sample is dropped.

// File: rtl/dyn_gain_pkg.sv
package dyn_gain_pkg;

  typedef enum logic {
    MODE_UNITY = 1'b0,
    MODE_BOOST = 1'b1
  } gain_mode_e;

  localparam logic [31:0] DEF_ATT_HYST  = 32'h0000_0100;
  localparam logic [31:0] DEF_REL_HYST  = 32'h0000_0300;
  localparam logic [31:0] DEF_ATT_DEB   = 32'h0000_0200;
  localparam logic [31:0] DEF_REL_DEB   = 32'h0004_B000;
  localparam logic [31:0] DEF_ATT_ALPHA = 32'h50FC_645C;
  localparam logic [31:0] DEF_ATT_BETA  = 32'h2F03_9BA4;
  localparam logic [31:0] DEF_REL_ALPHA = 32'h7FB5_1650;
  localparam logic [31:0] DEF_REL_BETA  = 32'h004A_E9B0;

  // Threshold in dB Q8; codes above 9 fold onto 9.
  function automatic logic signed [31:0] thr_from_code(input logic [3:0] code);
    int c;
    c = (code > 4'd9) ? 9 : int'(code);
    return 32'(-(12 + 6 * c) * 256);
  endfunction

  // Maximum gain in dB Q8; code 15 folds onto 14.
  function automatic logic [31:0] max_from_code(input logic [3:0] code);
    int c;
    c = (code == 4'd15) ? 14 : int'(code);
    return 32'(2 * (c + 1) * 256);
  endfunction

endpackage

// File: rtl/dyn_gain_decide.sv
module dyn_gain_decide
  import dyn_gain_pkg::*;
#(
  parameter int LVL_W = 16,
  parameter int CNT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc,
  input  logic signed [LVL_W-1:0] lvl,
  input  logic signed [31:0]      thr_q8,
  input  logic [31:0]             att_hy,
  input  logic [31:0]             rel_hy,
  input  logic [CNT_W-1:0]        att_lim,
  input  logic [CNT_W-1:0]        rel_lim,
  output gain_mode_e              mode_nxt
);
  localparam int CMP_W = 34;

  gain_mode_e       mode_q;
  logic [CNT_W-1:0] att_cnt, rel_cnt, att_nxt, rel_nxt;
  logic [CNT_W:0]   att_inc, rel_inc;
  logic signed [CMP_W-1:0] lvl_x, thr_x, lo_bound, hi_bound;
  logic is_low, is_high;

  assign lvl_x    = CMP_W'(lvl);
  assign thr_x    = CMP_W'(thr_q8);
  assign lo_bound = thr_x - CMP_W'($signed(rel_hy));
  assign hi_bound = thr_x + CMP_W'($signed(att_hy));
  assign is_low   = lvl_x < lo_bound;
  assign is_high  = lvl_x > hi_bound;
  assign att_inc  = {1'b0, att_cnt} + 1'b1;
  assign rel_inc  = {1'b0, rel_cnt} + 1'b1;

  always_comb begin
    mode_nxt = mode_q;
    att_nxt  = att_cnt;
    rel_nxt  = rel_cnt;
    if (mode_q == MODE_UNITY) begin
      if (!is_low) begin
        rel_nxt = '0;
      end else if (rel_inc >= {1'b0, rel_lim}) begin
        mode_nxt = MODE_BOOST;
        rel_nxt  = '0;
        att_nxt  = '0;
      end else begin
        rel_nxt = rel_inc[CNT_W-1:0];
      end
    end else begin
      if (!is_high) begin
        att_nxt = '0;
      end else if (att_inc >= {1'b0, att_lim}) begin
        mode_nxt = MODE_UNITY;
        rel_nxt  = '0;
        att_nxt  = '0;
      end else begin
        att_nxt = att_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_UNITY;
      att_cnt <= '0;
      rel_cnt <= '0;
    end else if (acc) begin
      mode_q  <= mode_nxt;
      att_cnt <= att_nxt;
      rel_cnt <= rel_nxt;
    end
  end

  // R4: a level not below the release bound never starts a boost
  a_r4_no_early_boost: assert property (@(posedge clk) disable iff (rst)
    (acc && mode_q == MODE_UNITY && !(lvl_x < lo_bound)) |=> mode_q == MODE_UNITY);

  // R10: mode stays put without an accepted level
  a_r10_hold_mode: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(mode_q));

endmodule

// File: rtl/dyn_gain_smooth.sv
module dyn_gain_smooth
  import dyn_gain_pkg::*;
#(
  parameter int EXT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc,
  input  gain_mode_e  mode_nxt,
  input  logic [31:0] max_q8,
  input  logic [31:0] att_a,
  input  logic [31:0] att_b,
  input  logic [31:0] rel_a,
  input  logic [31:0] rel_b,
  output logic signed [31:0] g_q
);
  localparam int PROD_W = 64;

  logic signed [31:0]       max_ext, tgt, a_sel, b_sel, g_nxt;
  logic signed [PROD_W-1:0] p_a, p_b, sum, shifted;

  assign max_ext = $signed(max_q8 << EXT_W);
  assign a_sel   = $signed((mode_nxt == MODE_BOOST) ? rel_a : att_a);
  assign b_sel   = $signed((mode_nxt == MODE_BOOST) ? rel_b : att_b);
  assign tgt     = (mode_nxt == MODE_BOOST) ? max_ext : 32'sd0;
  assign p_a     = PROD_W'(a_sel) * PROD_W'(g_q);
  assign p_b     = PROD_W'(b_sel) * PROD_W'(tgt);
  assign sum     = p_a + p_b;
  assign shifted = sum >>> 31;

  always_comb begin
    if (shifted < 0)                    g_nxt = 32'sd0;
    else if (shifted > PROD_W'(max_ext)) g_nxt = max_ext;
    else                                g_nxt = shifted[31:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      g_q <= 32'sd0;
    else if (acc) g_q <= g_nxt;
  end

  // R7: every update lands inside [0, max]
  a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
    acc |=> (g_q >= 0 && g_q <= $past(max_ext)));

  // R6: unity mode from zero gain stays at zero
  a_r6_unity_zero: assert property (@(posedge clk) disable iff (rst)
    (acc && mode_nxt == MODE_UNITY && g_q == 0) |=> g_q == 0);

endmodule

// File: rtl/dyn_gain_ctrl.sv
module dyn_gain_ctrl
  import dyn_gain_pkg::*;
#(
  parameter int LVL_W  = 16,
  parameter int GAIN_W = 16,
  parameter int CNT_W  = 24,
  parameter int EXT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lvl_valid,
  output logic                    lvl_ready,
  input  logic signed [LVL_W-1:0] lvl_db,
  output logic                    gain_valid,
  input  logic                    gain_ready,
  output logic [GAIN_W-1:0]       gain_db,
  input  logic [3:0]              thr_code,
  input  logic [3:0]              max_code,
  input  logic                    ovr_en,
  input  logic [31:0]             att_hyst,
  input  logic [31:0]             rel_hyst,
  input  logic [31:0]             att_deb,
  input  logic [31:0]             rel_deb,
  input  logic [31:0]             att_alpha,
  input  logic [31:0]             att_beta,
  input  logic [31:0]             rel_alpha,
  input  logic [31:0]             rel_beta
);
  localparam int DEB_SH = 8;

  logic             acc;
  gain_mode_e       mode_nxt;
  logic signed [31:0] g_q;
  logic [31:0]      e_ahy, e_rhy, e_adb, e_rdb, e_aa, e_ab, e_ra, e_rb;

  assign e_ahy = ovr_en ? att_hyst  : DEF_ATT_HYST;
  assign e_rhy = ovr_en ? rel_hyst  : DEF_REL_HYST;
  assign e_adb = ovr_en ? att_deb   : DEF_ATT_DEB;
  assign e_rdb = ovr_en ? rel_deb   : DEF_REL_DEB;
  assign e_aa  = ovr_en ? att_alpha : DEF_ATT_ALPHA;
  assign e_ab  = ovr_en ? att_beta  : DEF_ATT_BETA;
  assign e_ra  = ovr_en ? rel_alpha : DEF_REL_ALPHA;
  assign e_rb  = ovr_en ? rel_beta  : DEF_REL_BETA;

  assign lvl_ready = !gain_valid || gain_ready;
  assign acc       = lvl_valid && lvl_ready;

  dyn_gain_decide #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_decide (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .lvl      (lvl_db),
    .thr_q8   (thr_from_code(thr_code)),
    .att_hy   (e_ahy),
    .rel_hy   (e_rhy),
    .att_lim  (CNT_W'(e_adb >> DEB_SH)),
    .rel_lim  (CNT_W'(e_rdb >> DEB_SH)),
    .mode_nxt (mode_nxt)
  );

  dyn_gain_smooth #(.EXT_W(EXT_W)) u_smooth (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .mode_nxt (mode_nxt),
    .max_q8   (max_from_code(max_code)),
    .att_a    (e_aa),
    .att_b    (e_ab),
    .rel_a    (e_ra),
    .rel_b    (e_rb),
    .g_q      (g_q)
  );

  always_ff @(posedge clk) begin
    if (rst)      gain_valid <= 1'b0;
    else if (acc) gain_valid <= 1'b1;
    else if (gain_ready) gain_valid <= 1'b0;
  end

  assign gain_db = GAIN_W'(g_q >>> EXT_W);

  // R9: a stalled result holds still
  a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
    (gain_valid && !gain_ready) |=> (gain_valid && $stable(gain_db)));

  // R9: an accepted level always yields a result next edge
  a_r9_result_follows: assert property (@(posedge clk) disable iff (rst)
    acc |=> gain_valid);

endmodule

// File: tb/dyn_gain_ctrl_tb_top.sv
module dyn_gain_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EXT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lvl_valid = 1'b0;
  logic lvl_ready;
  logic signed [15:0] lvl_db = '0;
  logic gain_valid;
  logic gain_ready = 1'b1;
  logic [15:0] gain_db;
  logic [3:0] thr_code = 4'd7, max_code = 4'd11;
  logic ovr_en = 1'b0;
  logic [31:0] att_hyst = 0, rel_hyst = 0, att_deb = 0, rel_deb = 0;
  logic [31:0] att_alpha = 0, att_beta = 0, rel_alpha = 0, rel_beta = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  bit m_boost = 0;
  longint m_ac = 0, m_rc = 0, m_g = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dyn_gain_ctrl dut_i (
    .clk(clk), .rst(rst), .lvl_valid(lvl_valid), .lvl_ready(lvl_ready),
    .lvl_db(lvl_db), .gain_valid(gain_valid), .gain_ready(gain_ready),
    .gain_db(gain_db), .thr_code(thr_code), .max_code(max_code),
    .ovr_en(ovr_en), .att_hyst(att_hyst), .rel_hyst(rel_hyst),
    .att_deb(att_deb), .rel_deb(rel_deb), .att_alpha(att_alpha),
    .att_beta(att_beta), .rel_alpha(rel_alpha), .rel_beta(rel_beta)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint s32(input logic [31:0] v);
    logic signed [31:0] t;
    t = $signed(v);
    return longint'(t);
  endfunction

  function automatic longint thr_model();
    int c = (thr_code > 9) ? 9 : int'(thr_code);
    return -(12 + 6 * c) * 256;
  endfunction

  function automatic longint max_model();
    int c = (max_code == 15) ? 14 : int'(max_code);
    return longint'(2 * (c + 1) * 256) << EXT;
  endfunction

  task automatic model_step(input longint lvl);
    longint t, ah, rh, al, rl, a, b, tg, s;
    t  = thr_model();
    ah = ovr_en ? s32(att_hyst) : 256;
    rh = ovr_en ? s32(rel_hyst) : 768;
    al = (ovr_en ? longint'(att_deb) : 512) >> 8;
    rl = (ovr_en ? longint'(rel_deb) : 32'h4B000) >> 8;
    if (!m_boost) begin
      if (lvl < t - rh) begin
        m_rc++;
        if (m_rc >= rl) begin m_boost = 1; m_rc = 0; m_ac = 0; end
      end else m_rc = 0;
    end else begin
      if (lvl > t + ah) begin
        m_ac++;
        if (m_ac >= al) begin m_boost = 0; m_rc = 0; m_ac = 0; end
      end else m_ac = 0;
    end
    if (m_boost) begin
      a = ovr_en ? s32(rel_alpha) : s32(32'h7FB51650);
      b = ovr_en ? s32(rel_beta)  : s32(32'h004AE9B0);
      tg = max_model();
    end else begin
      a = ovr_en ? s32(att_alpha) : s32(32'h50FC645C);
      b = ovr_en ? s32(att_beta)  : s32(32'h2F039BA4);
      tg = 0;
    end
    s = (a * m_g + b * tg) >>> 31;
    if (s < 0) s = 0;
    else if (s > max_model()) s = max_model();
    m_g = s;
  endtask

  task automatic do_sample(input longint lvl, input string req);
    @(negedge clk);
    lvl_valid = 1'b1;
    lvl_db = 16'(lvl);
    model_step(lvl);
    @(negedge clk);
    lvl_valid = 1'b0;
    chk(gain_valid == 1'b1, {req, " R9 valid"}, longint'(gain_valid), 1);
    chk(longint'(gain_db) == (m_g >> EXT), req, longint'(gain_db), m_g >> EXT);
  endtask

  task automatic script(input string req);
    int off [14] = '{-3, -3, -1, -3, -3, -3, -3, 1, 2, 2, 2, -4, -4, -4};
    for (int k = 0; k < 14; k++) do_sample(thr_model() + off[k] * 256, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // decoy pin values while the fixed parameters are in force (R3)
    att_hyst = 0; rel_hyst = 0; att_deb = 32'h100; rel_deb = 32'h100;
    att_alpha = 0; att_beta = 32'h7FFFFFFF; rel_alpha = 0; rel_beta = 32'h7FFFFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(gain_valid == 1'b0, "R8 valid", longint'(gain_valid), 0);
    chk(lvl_ready == 1'b1, "R8 ready", longint'(lvl_ready), 1);
    chk(gain_db == 16'd0, "R8 gain", longint'(gain_db), 0);

    // R3 fixed parameters: 1200 quiet samples to release, 2 loud to attack
    for (int i = 0; i < 1250; i++) do_sample(-60 * 256, "R3 R4");
    chk(m_boost == 1, "R3 model", 0, 0);
    do_sample(-53 * 256, "R3 R5 bound");
    do_sample(-52 * 256, "R3 R5");
    do_sample(-52 * 256, "R3 R5");
    do_sample(-52 * 256, "R3 R5");

    // sweep every threshold and max-gain code with programmed parameters
    ovr_en = 1'b1;
    att_hyst = 32'h100; rel_hyst = 32'h200; att_deb = 32'h200; rel_deb = 32'h300;
    att_alpha = 32'h40000000; att_beta = 32'h40000000;
    rel_alpha = 32'h60000000; rel_beta = 32'h20000000;
    for (int t = 0; t < 16; t++)
      for (int m = 0; m < 16; m++) begin
        thr_code = 4'(t); max_code = 4'(m);
        script("R1 R2 R4 R5 R6");
      end

    // R7 saturation at the top, then a lowered maximum
    rel_alpha = 32'h7FFFFFFF; rel_beta = 32'h7FFFFFFF; max_code = 4'd14; thr_code = 4'd2;
    script("R7 high");
    for (int i = 0; i < 4; i++) do_sample(thr_model() - 1024, "R7 high");
    max_code = 4'd3;
    do_sample(thr_model() - 1024, "R7 lowered");
    // R7 negative beta clamps to zero
    rel_alpha = 32'h0; rel_beta = 32'hC0000000;
    do_sample(thr_model() - 1024, "R7 low");

    // R9 / R10 back-pressure
    rel_alpha = 32'h60000000; rel_beta = 32'h20000000; max_code = 4'd11;
    do_sample(thr_model() - 1024, "R9");
    @(negedge clk);
    gain_ready = 1'b0;
    do_sample(thr_model() - 1024, "R9 stall");
    @(negedge clk);
    lvl_valid = 1'b1; lvl_db = 16'(thr_model() + 2048);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(lvl_ready == 1'b0, "R9 ready", longint'(lvl_ready), 0);
      chk(gain_valid == 1'b1, "R9 held", longint'(gain_valid), 1);
      chk(longint'(gain_db) == (m_g >> EXT), "R9 hold", longint'(gain_db), m_g >> EXT);
    end
    lvl_valid = 1'b0;
    @(negedge clk);
    gain_ready = 1'b1;
    @(negedge clk);
    chk(gain_valid == 1'b0, "R9 drained", longint'(gain_valid), 0);
    // stalled loud sample must not have counted toward an attack (R10)
    do_sample(thr_model() + 2048, "R10");
    do_sample(thr_model() - 1024, "R10");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule